// File: doc/BRIEF.md
# Per-Opcode Trivial Taint Propagation Filter

This block sits in the lookup stage of an in-order taint propagation pipeline. For each opcode it holds a 2-bit mode. The mode says whether the output taint state of an instruction can be worked out at once from its input taint states, without asking the slower response cache. Each lookup presents an opcode and the taint states of its operands: first register, second register and memory. The block answers in the same cycle. It returns either an immediate output state or an indication that a full lookup is needed. An operand that is not used is presented as an all-zero state.

The block has two fast paths. The zero path covers the case where every input state is zero, and then the output state is zero. The unary path covers the case where exactly one input state is nonzero, and then the output equals that state. Each opcode enables none, one or both of these paths through its mode.

System software saves and restores the whole table on a context switch through a word-wide port. The port moves 16 entries per 32-bit word.

Top module: `taint_filter_tbl`

## Requirements
- R1: After reset every entry holds mode 00. Every lookup then reports `lk_fast` = 0, and every table word reads back as zero.
- R2: Table word k holds opcode 16k+j in bits [2j+1:2j]. `cfg_rdata` shows the word selected by `cfg_addr` in the same cycle, without waiting for a clock edge.
- R3: When `cfg_we` is high, the rising clock edge replaces all 16 entries of the addressed word with `cfg_wdata`. Other words keep their contents.
- R4: Mode 00 and mode 11 give `lk_fast` = 0 for every combination of input states.
- R5: Mode 01 gives `lk_fast` = 1 and `lk_state` = 0 when all three input states are zero. With any nonzero input it gives `lk_fast` = 0.
- R6: Mode 10 gives `lk_fast` = 1 and `lk_state` = 0 when all three input states are zero.
- R7: Mode 10 gives `lk_fast` = 1 when exactly one input state is nonzero, and `lk_state` equals that state, whichever operand carries it. Operand i occupies `lk_src` bits [2i+1:2i]: 0 is the first register, 1 the second register, 2 memory.
- R8: Two or more nonzero input states give `lk_fast` = 0 under every mode.
- R9: The lookup result is combinational from `lk_opcode` and `lk_src`. A lookup made in the same cycle as a write to its own entry uses the mode held before that write.
- R10: Whenever `lk_fast` = 0, `lk_state` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_opcode | input | 8 | Opcode of the instruction being looked up |
| lk_src | input | 6 | Three input taint states, 2 bits each |
| lk_fast | output | 1 | 1 = the trivial result is valid; 0 = a full lookup is needed |
| lk_state | output | 2 | Immediate output taint state |
| cfg_we | input | 1 | Write strobe for a table word |
| cfg_addr | input | 4 | Table word index |
| cfg_wdata | input | 32 | Word to write |
| cfg_rdata | output | 32 | Contents of the word selected by `cfg_addr` |

## Verification
A save/restore write and a lookup of an entry inside the word being written can fall in the same cycle. The bench provokes this by raising `cfg_we` for word 0 while `lk_opcode` selects opcode 0 with all-zero inputs. It samples `lk_fast` before the edge and expects the old mode 01 to give a fast result. It samples again after the edge and expects the new mode 00 to send the instruction for a full lookup.

// File: rtl/taint_filter_tbl.sv
module taint_filter_tbl #(
  parameter int OPC_W  = 8,
  parameter int ST_W   = 2,
  parameter int NSRC   = 3,
  parameter int WORD_W = 32,
  localparam int ENTRIES  = 1 << OPC_W,
  localparam int PER_WORD = WORD_W / 2,
  localparam int WORDS    = ENTRIES / PER_WORD,
  localparam int ADDR_W   = $clog2(WORDS),
  localparam int SEL_W    = $clog2(PER_WORD)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OPC_W-1:0]     lk_opcode,
  input  logic [NSRC*ST_W-1:0] lk_src,
  output logic                 lk_fast,
  output logic [ST_W-1:0]      lk_state,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [WORD_W-1:0]    cfg_wdata,
  output logic [WORD_W-1:0]    cfg_rdata
);
  localparam int CNT_W = $clog2(NSRC + 1);

  logic [1:0]       tbl [ENTRIES];
  logic [1:0]       mode;
  logic [CNT_W-1:0] nz_cnt;
  logic [ST_W-1:0]  any_st;
  logic             zero_ok, unary_ok, one_nz, none_nz;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        tbl[e] <= 2'b00;
      else if (cfg_we && cfg_addr == ADDR_W'(e / PER_WORD))
        tbl[e] <= cfg_wdata[2*(e % PER_WORD) +: 2];
  end

  for (genvar j = 0; j < PER_WORD; j++) begin : g_rd
    assign cfg_rdata[2*j +: 2] = tbl[{cfg_addr, SEL_W'(j)}];
  end

  always_comb begin
    nz_cnt = '0;
    any_st = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (|lk_src[i*ST_W +: ST_W]) nz_cnt = nz_cnt + CNT_W'(1);
      any_st = any_st | lk_src[i*ST_W +: ST_W];
    end
  end

  assign mode     = tbl[lk_opcode];
  assign zero_ok  = (mode == 2'b01) || (mode == 2'b10);
  assign unary_ok = (mode == 2'b10);
  assign none_nz  = (nz_cnt == '0);
  assign one_nz   = (nz_cnt == CNT_W'(1));
  assign lk_fast  = (zero_ok && none_nz) || (unary_ok && one_nz);
  assign lk_state = (unary_ok && one_nz) ? any_st : '0;
endmodule

// File: rtl/taint_filter_chk.sv
module taint_filter_chk #(
  parameter int ST_W   = 2,
  parameter int NSRC   = 3,
  parameter int ADDR_W = 4,
  parameter int WORD_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NSRC*ST_W-1:0] lk_src,
  input logic                 lk_fast,
  input logic [ST_W-1:0]      lk_state,
  input logic                 cfg_we,
  input logic [ADDR_W-1:0]    cfg_addr,
  input logic [WORD_W-1:0]    cfg_wdata,
  input logic [WORD_W-1:0]    cfg_rdata
);
  int              nz;
  logic [ST_W-1:0] only;

  always_comb begin
    nz   = 0;
    only = '0;
    for (int i = 0; i < NSRC; i++)
      if (lk_src[i*ST_W +: ST_W] != '0) begin
        nz   = nz + 1;
        only = lk_src[i*ST_W +: ST_W];
      end
  end

  assert_slow_is_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_fast |-> lk_state == '0);
  assert_zero_in_zero_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fast && nz == 0) |-> lk_state == '0);
  assert_unary_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fast && nz == 1) |-> lk_state == only);
  assert_multi_slow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nz >= 2) |-> !lk_fast);
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && cfg_addr == $past(cfg_addr)) |-> cfg_rdata == $past(cfg_wdata));
endmodule

bind taint_filter_tbl taint_filter_chk #(
  .ST_W(ST_W), .NSRC(NSRC), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_src(lk_src), .lk_fast(lk_fast),
  .lk_state(lk_state), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
);

// File: tb/taint_filter_tbl_bench.sv
module taint_filter_tbl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  lk_opcode = '0;
  logic [5:0]  lk_src = '0;
  logic        lk_fast;
  logic [1:0]  lk_state;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  taint_filter_tbl u_taint_filter_tbl (
    .clk(clk), .rst_n(rst_n), .lk_opcode(lk_opcode), .lk_src(lk_src),
    .lk_fast(lk_fast), .lk_state(lk_state), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  // {opcode, src(mem,r2,r1), expected fast, expected state}
  localparam logic [16:0] VEC [NVEC] = '{
    {8'd0,   6'b000000, 1'b1, 2'd0},
    {8'd0,   6'b000001, 1'b0, 2'd0},
    {8'd1,   6'b000000, 1'b1, 2'd0},
    {8'd1,   6'b000010, 1'b1, 2'd2},
    {8'd1,   6'b001100, 1'b1, 2'd3},
    {8'd1,   6'b010000, 1'b1, 2'd1},
    {8'd1,   6'b000101, 1'b0, 2'd0},
    {8'd1,   6'b111111, 1'b0, 2'd0},
    {8'd2,   6'b000000, 1'b0, 2'd0},
    {8'd3,   6'b000000, 1'b0, 2'd0},
    {8'd255, 6'b100000, 1'b1, 2'd2},
    {8'd240, 6'b000000, 1'b1, 2'd0},
    {8'd240, 6'b110000, 1'b0, 2'd0},
    {8'd4,   6'b000000, 1'b0, 2'd0}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_word(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [7:0] op, input logic [5:0] s);
    @(negedge clk);
    lk_opcode = op; lk_src = s;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    cfg_addr = 4'd0; look(8'd0, 6'b000000);
    check("R1 fast after reset", {31'd0, lk_fast}, 32'd0);
    check("R1 word0 after reset", cfg_rdata, 32'd0);
    cfg_addr = 4'd15; #1;
    check("R1 word15 after reset", cfg_rdata, 32'd0);

    // R2, R3: op0=01, op1=10, op2=11, op3=00; op240=01, op255=10
    wr_word(4'd0, 32'h0000_0039);
    wr_word(4'd15, 32'h8000_0001);
    cfg_addr = 4'd0; #1;
    check("R2 word0 readback", cfg_rdata, 32'h0000_0039);
    cfg_addr = 4'd15; #1;
    check("R2 word15 readback", cfg_rdata, 32'h8000_0001);
    cfg_addr = 4'd7; #1;
    check("R3 untouched word stays zero", cfg_rdata, 32'd0);

    // vector table: R4, R5, R6, R7, R8, R10
    for (int k = 0; k < NVEC; k++) begin
      look(VEC[k][16:9], VEC[k][8:3]);
      check($sformatf("R4,R5,R6,R7,R8 vec %0d fast", k), {31'd0, lk_fast}, {31'd0, VEC[k][2]});
      check($sformatf("R7,R10 vec %0d state", k), {30'd0, lk_state}, {30'd0, VEC[k][1:0]});
    end

    // R9: same-cycle write and lookup of opcode 0 (01 -> 00)
    @(negedge clk);
    lk_opcode = 8'd0; lk_src = 6'b000000;
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 32'h0000_0038;
    #1;
    check("R9 lookup uses old mode", {31'd0, lk_fast}, 32'd1);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    check("R9 new mode after edge", {31'd0, lk_fast}, 32'd0);
    check("R3 other entries in word kept", cfg_rdata, 32'h0000_0038);
    look(8'd1, 6'b000011);
    check("R3 op1 still unary", {29'd0, lk_fast, lk_state}, 32'h7);

    // R1: reset mid-run clears table
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cfg_addr = 4'd15; look(8'd255, 6'b100000);
    check("R1 word15 cleared by reset", cfg_rdata, 32'd0);
    check("R1 op255 slow after reset", {31'd0, lk_fast}, 32'd0);

    finish_run();
  end
endmodule